// File: doc/BRIEF.md
# Cross-Domain Count Handoff

This block moves a binary count word from one clock domain into a second, unrelated clock domain. The source side copies its live count into a holding register, freezes that register, and flips a request level. The destination side synchronizes the request level through a short flop chain. When it sees the level change, it copies the frozen word and flips an acknowledge level back toward the source. Once the source sees the synchronized acknowledge change, it re-arms and samples the count again.

Only one word is in flight at a time, and the held word never moves while the other side may be reading it. For that reason the count may be any binary value. It may jump by many steps, and it may come from a counter whose modulus is not a power of two. The destination presents the last captured word and pulses a strobe for one cycle whenever that word changes. Reset clears both toggles and the output. The first transfer begins on its own once the source leaves reset.

Top module: `xb_count_bridge`

## Requirements
- R1: The source holding register stays unchanged from the cycle it samples until the cycle the synchronized acknowledge change is seen.
- R2: The source request level changes only when the previous request has been acknowledged, so at most one transfer is in flight; no acknowledge change arrives while the source is not waiting for one.
- R3: When the source count is held steady, `dst_value` settles to that count.
- R4: Any word passes unchanged, including jumps across the full range such as 0xFF to 0x00 and 0x7F to 0x80 and back.
- R5: With the source fed by a counter that wraps from 9 to 0, every word captured at the destination lies in 0..9, and after the counter stops the output equals its final value.
- R6: A change of the source count reaches `dst_value` no sooner than the third rising edge of `dst_clk` after the change, which is at least two destination cycles of crossing latency.
- R7: `dst_update` is high for exactly one `dst_clk` cycle each time `dst_value` takes a new value, and never otherwise; a transfer that repeats the current value gives no strobe.
- R8: While reset is held, `dst_value` is 0 and `dst_update` is 0; after reset releases, the count present at the source is delivered with no further stimulus, with one strobe if it is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| src_count | input | WIDTH | Live binary count in the source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| dst_value | output | WIDTH | Last count captured in the destination domain |
| dst_update | output | 1 | One-cycle pulse when dst_value changes |

## Verification
A source side that lets the holding register move during a transfer shows up as a destination word that was never a legal count. The most likely place to see it is the modulo-ten run, within one round trip. A lost or doubled toggle stops delivery for good or repeats stale words, and a steady input then fails to settle within a few dozen destination cycles. A wrong strobe condition shows at once as a pulse count per window that differs from whether the settled value changed. A missing synchronizer stage makes the measured change-to-output edge count drop below three.

// File: rtl/xb_pkg.sv
package xb_pkg;

  typedef enum logic {
    SRC_ARM  = 1'b0,
    SRC_WAIT = 1'b1
  } src_state_e;

  // An event on a toggle line is a difference between the synchronized
  // level and the level last consumed.
  function automatic logic toggle_event(input logic now_lvl, input logic seen_lvl);
    return now_lvl ^ seen_lvl;
  endfunction

endpackage

// File: rtl/xb_level_sync.sv
module xb_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $fatal(1, "xb_level_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], d};
  end

  assign q = chain_q[LAST];
endmodule

// File: rtl/xb_src_side.sv
module xb_src_side
  import xb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] count_in,
  input  logic             ack_lvl_s,
  output logic [WIDTH-1:0] hold_q,
  output logic             req_lvl,
  output logic             ack_evt
);
  src_state_e state_q;
  logic       ack_seen_q;

  assign ack_evt = toggle_event(ack_lvl_s, ack_seen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SRC_ARM;
      hold_q     <= '0;
      req_lvl    <= 1'b0;
      ack_seen_q <= 1'b0;
    end else begin
      if (ack_evt) ack_seen_q <= ack_lvl_s;
      case (state_q)
        SRC_ARM: begin
          hold_q  <= count_in;
          req_lvl <= ~req_lvl;
          state_q <= SRC_WAIT;
        end
        SRC_WAIT: begin
          if (ack_evt) state_q <= SRC_ARM;
        end
        default: state_q <= SRC_ARM;
      endcase
    end
  end

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SRC_WAIT && !ack_evt) |=> $stable(hold_q)); // R1

  AST_REQ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_lvl != $past(req_lvl)) |-> ($past(ack_seen_q) == $past(req_lvl))); // R2

  AST_ACK_SOLICITED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |-> (state_q == SRC_WAIT)); // R2
endmodule

// File: rtl/xb_dst_side.sv
module xb_dst_side
  import xb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] hold_in,
  input  logic             req_lvl_s,
  output logic [WIDTH-1:0] value_q,
  output logic             update_q,
  output logic             ack_lvl,
  output logic             req_evt
);
  logic req_seen_q;

  function automatic logic word_differs(input logic [WIDTH-1:0] a,
                                        input logic [WIDTH-1:0] b);
    return |(a ^ b);
  endfunction

  assign req_evt = toggle_event(req_lvl_s, req_seen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen_q <= 1'b0;
      value_q    <= '0;
      update_q   <= 1'b0;
      ack_lvl    <= 1'b0;
    end else begin
      update_q <= 1'b0;
      if (req_evt) begin
        req_seen_q <= req_lvl_s;
        value_q    <= hold_in;
        update_q   <= word_differs(hold_in, value_q);
        ack_lvl    <= ~ack_lvl;
      end
    end
  end

  AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    update_q |-> (value_q != $past(value_q))); // R7

  AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (value_q != $past(value_q)) |-> update_q); // R7

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    update_q |=> !update_q); // R7
endmodule

// File: rtl/xb_count_bridge.sv
module xb_count_bridge #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic [WIDTH-1:0] src_count,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic [WIDTH-1:0] dst_value,
  output logic             dst_update
);
  logic [WIDTH-1:0] held_word;
  logic             req_lvl, req_lvl_s;
  logic             ack_lvl, ack_lvl_s;
  logic             src_ack_evt, dst_req_evt;

  xb_src_side #(.WIDTH(WIDTH)) i_src (
    .clk      (src_clk),
    .rst_n    (src_rst_n),
    .count_in (src_count),
    .ack_lvl_s(ack_lvl_s),
    .hold_q   (held_word),
    .req_lvl  (req_lvl),
    .ack_evt  (src_ack_evt)
  );

  xb_level_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
    .clk  (dst_clk),
    .rst_n(dst_rst_n),
    .d    (req_lvl),
    .q    (req_lvl_s)
  );

  xb_level_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
    .clk  (src_clk),
    .rst_n(src_rst_n),
    .d    (ack_lvl),
    .q    (ack_lvl_s)
  );

  xb_dst_side #(.WIDTH(WIDTH)) i_dst (
    .clk      (dst_clk),
    .rst_n    (dst_rst_n),
    .hold_in  (held_word),
    .req_lvl_s(req_lvl_s),
    .value_q  (dst_value),
    .update_q (dst_update),
    .ack_lvl  (ack_lvl),
    .req_evt  (dst_req_evt)
  );

  // A capture happens only while the source is holding a word for it.
  AST_CAPTURE_WHILE_HELD: assert property (@(posedge dst_clk) disable iff (!dst_rst_n || !src_rst_n)
    dst_req_evt |-> (req_lvl != ack_lvl)); // R2
endmodule

// File: tb/test_xb_count_bridge.sv
module test_xb_count_bridge;
  localparam int SRC_PERIOD = 10;
  localparam int DST_PERIOD = 14;
  localparam int W          = 8;
  localparam int SETTLE     = 30;

  // {stimulus word, expected strobe count in the settle window}
  localparam logic [W:0] VEC [0:9] = '{
    {8'h01, 1'b1}, {8'h01, 1'b0}, {8'hFF, 1'b1}, {8'h00, 1'b1}, {8'h80, 1'b1},
    {8'h7F, 1'b1}, {8'h7F, 1'b0}, {8'hC3, 1'b1}, {8'h3C, 1'b1}, {8'h00, 1'b1}
  };

  logic         src_clk = 1'b0, dst_clk = 1'b0;
  logic         src_rst_n = 1'b0, dst_rst_n = 1'b0;
  logic [W-1:0] src_count = 8'h5A;
  logic [W-1:0] dst_value;
  logic         dst_update;

  int checks = 0, fails = 0;
  int upd_total = 0, mod_bad = 0, mod_upd = 0;
  bit mod_mon = 1'b0;
  bit done = 1'b0;

  always #(SRC_PERIOD/2) src_clk = ~src_clk;
  always #(DST_PERIOD/2) dst_clk = ~dst_clk;

  xb_count_bridge #(.WIDTH(W), .SYNC_STAGES(2)) i_xb_count_bridge (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_count (src_count),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_value (dst_value),
    .dst_update(dst_update)
  );

  always @(negedge dst_clk) begin
    if (dst_update) upd_total++;
    if (mod_mon && dst_update) begin
      mod_upd++;
      if (dst_value > 8'd9) mod_bad++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge dst_clk);
    #1;
  endtask

  initial begin
    #(200_000 * DST_PERIOD);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    int n;
    // R8: reset state, then automatic first transfer
    repeat (5) @(negedge dst_clk);
    #1;
    check(dst_value == '0, "R8 value in reset", dst_value, 0);
    check(dst_update == 1'b0, "R8 strobe in reset", dst_update, 0);
    base = upd_total;
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    settle();
    check(dst_value == 8'h5A, "R8 first transfer", dst_value, 8'h5A);
    check(upd_total - base == 1, "R8 first strobe", upd_total - base, 1);

    // R3 R4 R7: table of words and strobe expectations
    for (int i = 0; i < 10; i++) begin
      @(negedge src_clk);
      #1;
      src_count = VEC[i][W:1];
      base = upd_total;
      settle();
      check(dst_value == VEC[i][W:1], "R3/R4 settled word", dst_value, VEC[i][W:1]);
      check(upd_total - base == int'(VEC[i][0]), "R7 strobe count", upd_total - base, VEC[i][0]);
    end

    // R6: crossing latency
    @(negedge src_clk);
    #1;
    src_count = 8'h22;
    n = 0;
    for (int k = 0; k < 60; k++) begin
      @(posedge dst_clk);
      n++;
      #1;
      if (dst_value == 8'h22) break;
    end
    check(dst_value == 8'h22, "R6 word arrives", dst_value, 8'h22);
    check(n >= 3 && n <= 20, "R6 edge count", n, 3);

    // R5: modulo-ten counter at the source
    @(negedge src_clk);
    #1;
    src_count = 8'd0;
    settle();
    mod_mon = 1'b1;
    repeat (400) begin
      @(negedge src_clk);
      #1;
      src_count = (src_count == 8'd9) ? 8'd0 : src_count + 8'd1;
    end
    settle();
    mod_mon = 1'b0;
    check(mod_bad == 0, "R5 out-of-range word", mod_bad, 0);
    check(mod_upd >= 10, "R5 updates seen", mod_upd, 10);
    check(dst_value == src_count, "R5 final word", dst_value, src_count);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule